// File: doc/BRIEF.md
# Cell Header Translation Port

This block sits on one input of a cell switch and relabels fixed-size cells as they pass. Cells arrive one byte per transfer, 53 bytes each: a 5-byte header, then 48 payload bytes. The block gathers the header and checks its check byte. It pulls out the path and circuit labels and searches a 16-entry connection table for them. On a hit it writes the outgoing labels into the header, builds a new check byte and sends the cell on. The payload is copied through as it arrives. A cell whose check byte is wrong, or whose labels are not in the table, is thrown away in full, and a counter of discarded cells advances.

Two mode inputs control the lookup. The first chooses the header layout. In the host-facing layout the first four bits are a flow-control field and the path label is 8 bits. In the switch-facing layout those four bits belong to a 12-bit path label. The second mode input selects path-only switching, where only the path label is matched and replaced. The table is loaded through a plain indexed write port before traffic starts.

Top module: `cell_hdr_xlate`

## Requirements
- R1: A cell starts at a byte accepted with `in_soc` high while the block is idle. Bytes accepted while idle with `in_soc` low are discarded. On the output, `out_soc` is high on the first of each 53 emitted bytes and low on the other 52.
- R2: With the four leading header bytes taken as a word W (first byte in W[31:24]), the expected check byte is the CRC-8 of W with generator x^8+x^2+x+1 (0x07), initial value 0, MSB first, XORed with 0x55. If the fifth header byte differs from it, the whole cell is dropped and `drop_count` rises by exactly one.
- R3: The search returns the lowest-index valid entry that matches. If no entry matches, the cell is dropped and `drop_count` rises by one. A cell that both fails the check and misses the table is counted once.
- R4: In full mode (`path_only`=0), an entry matches when its key path equals the incoming path and its key circuit equals W[19:4]. The outgoing path and circuit are then written into the header.
- R5: In path-only mode (`path_only`=1), only the key path is compared, and W[19:4] leaves unchanged.
- R6: In host layout (`nni_mode`=0), the incoming path is {4'h0, W[27:20]}. W[31:28] passes through unchanged, and only the low 8 bits of the outgoing path are written into W[27:20]. In switch layout (`nni_mode`=1), the path is W[31:20] and all 12 bits are replaced.
- R7: W[3:0] (type and loss-priority bits) pass through unchanged. The emitted fifth header byte is the R2 check byte of the rewritten W.
- R8: The 48 payload bytes of a forwarded cell come out unchanged and in order.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_soc` hold. No input byte is accepted while header bytes are being emitted.
- R10: A pulse on `tbl_we` writes the entry at `tbl_idx` with `tbl_vld`, the keys and the outgoing labels. An entry written with `tbl_vld`=0 never matches.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, `drop_count` is 0 and every table entry is invalid, so every cell is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nni_mode | input | 1 | 1: switch-facing layout with 12-bit path; 0: host-facing layout |
| path_only | input | 1 | 1: match and rewrite the path label only |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_soc | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_soc | output | 1 | Output byte is the first byte of a cell |
| out_data | output | 8 | Output byte |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(N_ENTRY) | Entry to write |
| tbl_vld | input | 1 | Valid bit to store |
| tbl_key_path | input | 12 | Incoming path to match |
| tbl_key_circ | input | 16 | Incoming circuit to match |
| tbl_new_path | input | 12 | Outgoing path |
| tbl_new_circ | input | 16 | Outgoing circuit |
| drop_count | output | CNT_W | Number of discarded cells, wrapping |

## Verification
Header checking and the table search both resolve in the same decision cycle, and both can reject the same cell. The bench provokes this with a cell whose check byte is corrupted and whose labels are in no entry. It passes only if no byte of that cell appears on the output and the discard count rises by exactly one. Other cells are sent with the table holding duplicate keys and with downstream stalls. These confirm that priority, relabelling and the regenerated check byte stay correct in each layout and mode.

// File: rtl/cell_xlate_pkg.sv
package cell_xlate_pkg;

  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 5;
  localparam int PAY_BYTES  = CELL_BYTES - HDR_BYTES;
  localparam int PATH_W     = 12;
  localparam int CIRC_W     = 16;
  localparam int HDR_W      = 8 * HDR_BYTES;
  localparam logic [7:0] HEC_POLY = 8'h07;
  localparam logic [7:0] HEC_MASK = 8'h55;

  typedef enum logic [2:0] {
    S_HDR,
    S_DECIDE,
    S_EMIT,
    S_PAY,
    S_DROP
  } port_st_e;

  typedef struct packed {
    logic              vld;
    logic [PATH_W-1:0] kpath;
    logic [CIRC_W-1:0] kcirc;
    logic [PATH_W-1:0] npath;
    logic [CIRC_W-1:0] ncirc;
  } conn_t;

  // CRC-8 over a 32-bit header word, MSB first, remainder XOR mask
  function automatic logic [7:0] hec_calc(input logic [31:0] w);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ w[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ HEC_POLY;
    end
    return c ^ HEC_MASK;
  endfunction

endpackage

// File: rtl/cell_conn_table.sv
module cell_conn_table
  import cell_xlate_pkg::*;
#(
  parameter int N_ENTRY = 16,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  conn_t             wr_entry,
  input  logic [PATH_W-1:0] look_path,
  input  logic [CIRC_W-1:0] look_circ,
  input  logic              path_only,
  output logic              hit,
  output conn_t             hit_entry
);

  conn_t [N_ENTRY-1:0] ent_v;
  logic  [N_ENTRY-1:0] match_v;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    conn_t ent_q;
    logic  wr_sel;

    assign wr_sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (wr_sel) begin
        ent_q <= wr_entry;
      end
    end

    assign ent_v[g]   = ent_q;
    assign match_v[g] = ent_q.vld && (ent_q.kpath == look_path) &&
                        (path_only || (ent_q.kcirc == look_circ));
  end

  // lowest index wins: scan downwards so the last assignment is the lowest
  always_comb begin
    hit       = 1'b0;
    hit_entry = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (match_v[i]) begin
        hit       = 1'b1;
        hit_entry = ent_v[i];
      end
    end
  end

endmodule

// File: rtl/cell_hdr_rewrite.sv
module cell_hdr_rewrite
  import cell_xlate_pkg::*;
(
  input  logic [HDR_W-1:0]  hdr,
  input  logic              nni_mode,
  input  logic              path_only,
  input  conn_t             hit_entry,
  output logic              hec_ok,
  output logic [PATH_W-1:0] look_path,
  output logic [CIRC_W-1:0] look_circ,
  output logic [HDR_W-1:0]  new_hdr
);

  logic [31:0] w_in;
  logic [31:0] w_out;

  assign w_in      = hdr[HDR_W-1:8];
  assign hec_ok    = (hec_calc(w_in) == hdr[7:0]);
  assign look_path = nni_mode ? w_in[31:20] : {4'h0, w_in[27:20]};
  assign look_circ = w_in[19:4];

  always_comb begin
    w_out         = w_in;
    w_out[27:20]  = hit_entry.npath[7:0];
    if (nni_mode)   w_out[31:28] = hit_entry.npath[11:8];
    if (!path_only) w_out[19:4]  = hit_entry.ncirc;
  end

  assign new_hdr = {w_out, hec_calc(w_out)};

endmodule

// File: rtl/cell_hdr_xlate.sv
module cell_hdr_xlate
  import cell_xlate_pkg::*;
#(
  parameter int N_ENTRY = 16,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nni_mode,
  input  logic              path_only,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_soc,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_soc,
  output logic [7:0]        out_data,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic              tbl_vld,
  input  logic [PATH_W-1:0] tbl_key_path,
  input  logic [CIRC_W-1:0] tbl_key_circ,
  input  logic [PATH_W-1:0] tbl_new_path,
  input  logic [CIRC_W-1:0] tbl_new_circ,
  output logic [CNT_W-1:0]  drop_count
);

  localparam int BCNT_W = $clog2(PAY_BYTES);
  localparam logic [BCNT_W-1:0] HDR_LAST = BCNT_W'(HDR_BYTES - 1);
  localparam logic [BCNT_W-1:0] PAY_LAST = BCNT_W'(PAY_BYTES - 1);

  port_st_e           st_q, st_d;
  logic [BCNT_W-1:0]  cnt_q, cnt_d;
  logic [HDR_W-1:0]   hdr_q, hdr_d;
  logic [HDR_W-1:0]   ohdr_q, ohdr_d;
  logic [CNT_W-1:0]   drop_q, drop_d;

  conn_t              wr_entry;
  conn_t              hit_entry;
  logic               hit;
  logic               hec_ok;
  logic [PATH_W-1:0]  look_path;
  logic [CIRC_W-1:0]  look_circ;
  logic [HDR_W-1:0]   new_hdr;

  always_comb begin
    wr_entry.vld   = tbl_vld;
    wr_entry.kpath = tbl_key_path;
    wr_entry.kcirc = tbl_key_circ;
    wr_entry.npath = tbl_new_path;
    wr_entry.ncirc = tbl_new_circ;
  end

  cell_conn_table #(.N_ENTRY(N_ENTRY)) table_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_idx    (tbl_idx),
    .wr_entry  (wr_entry),
    .look_path (look_path),
    .look_circ (look_circ),
    .path_only (path_only),
    .hit       (hit),
    .hit_entry (hit_entry)
  );

  cell_hdr_rewrite rewrite_i (
    .hdr       (hdr_q),
    .nni_mode  (nni_mode),
    .path_only (path_only),
    .hit_entry (hit_entry),
    .hec_ok    (hec_ok),
    .look_path (look_path),
    .look_circ (look_circ),
    .new_hdr   (new_hdr)
  );

  // next-state and output decode
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    hdr_d     = hdr_q;
    ohdr_d    = ohdr_q;
    drop_d    = drop_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_soc   = 1'b0;
    out_data  = 8'h00;
    case (st_q)
      S_HDR: begin
        in_ready = 1'b1;
        if (in_valid && ((cnt_q != '0) || in_soc)) begin
          hdr_d = {hdr_q[HDR_W-9:0], in_data};
          if (cnt_q == HDR_LAST) begin
            st_d  = S_DECIDE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_DECIDE: begin
        if (hec_ok && hit) begin
          st_d   = S_EMIT;
          ohdr_d = new_hdr;
        end else begin
          st_d   = S_DROP;
          drop_d = drop_q + 1'b1;
        end
      end
      S_EMIT: begin
        out_valid = 1'b1;
        out_soc   = (cnt_q == '0);
        out_data  = ohdr_q[HDR_W-1 -: 8];
        if (out_ready) begin
          ohdr_d = {ohdr_q[HDR_W-9:0], 8'h00};
          if (cnt_q == HDR_LAST) begin
            st_d  = S_PAY;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_PAY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_data  = in_data;
        if (in_valid && out_ready) begin
          if (cnt_q == PAY_LAST) begin
            st_d  = S_HDR;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (cnt_q == PAY_LAST) begin
            st_d  = S_HDR;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        st_d  = S_HDR;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_HDR;
      cnt_q  <= '0;
      hdr_q  <= '0;
      ohdr_q <= '0;
      drop_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hdr_q  <= hdr_d;
      ohdr_q <= ohdr_d;
      drop_q <= drop_d;
    end
  end

  assign drop_count = drop_q;

endmodule

// File: rtl/cell_hdr_xlate_chk.sv
module cell_hdr_xlate_chk
  import cell_xlate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_soc,
  input logic [7:0]       out_data,
  input logic [CNT_W-1:0] drop_count
);

  logic [5:0]  ocnt_q;
  logic [31:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocnt_q <= '0;
      cap_q  <= '0;
    end else if (out_valid && out_ready) begin
      ocnt_q <= (ocnt_q == 6'(CELL_BYTES - 1)) ? 6'd0 : ocnt_q + 6'd1;
      if (ocnt_q < 6'd4) cap_q <= {cap_q[23:0], out_data};
    end
  end

  // R1: start flag exactly on byte 0 of every emitted cell
  p_soc_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_soc == (ocnt_q == 6'd0)));

  // R2: discard counter only ever steps by one
  p_drop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_count) |-> (drop_count == $past(drop_count) + 1'b1));

  // R3: a discard never coincides with emitted output
  p_drop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drop_count) |-> !out_valid);

  // R7: fifth emitted byte is the check byte of the four before it
  p_hec_regen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (ocnt_q == 6'd4)) |-> (out_data == hec_calc(cap_q)));

  // R9: stalled output holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_soc)));

  // R9: no input taken while a header start is presented
  p_emit_noin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_soc) |-> !in_ready);

endmodule

bind cell_hdr_xlate cell_hdr_xlate_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_soc    (out_soc),
  .out_data   (out_data),
  .drop_count (drop_count)
);

// File: tb/cell_hdr_xlate_tb.sv
module cell_hdr_xlate_tb_top;

  logic        clk;
  logic        rst_n;
  logic        nni_mode;
  logic        path_only;
  logic        in_valid;
  logic        in_ready;
  logic        in_soc;
  logic [7:0]  in_data;
  logic        out_valid;
  logic        out_ready;
  logic        out_soc;
  logic [7:0]  out_data;
  logic        tbl_we;
  logic [3:0]  tbl_idx;
  logic        tbl_vld;
  logic [11:0] tbl_key_path;
  logic [15:0] tbl_key_circ;
  logic [11:0] tbl_new_path;
  logic [15:0] tbl_new_circ;
  logic [15:0] drop_count;

  cell_hdr_xlate #(.N_ENTRY(16), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .nni_mode(nni_mode), .path_only(path_only),
    .in_valid(in_valid), .in_ready(in_ready), .in_soc(in_soc), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_soc(out_soc), .out_data(out_data),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_vld(tbl_vld),
    .tbl_key_path(tbl_key_path), .tbl_key_circ(tbl_key_circ),
    .tbl_new_path(tbl_new_path), .tbl_new_circ(tbl_new_circ),
    .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_drops = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_d[$];
  logic       exp_s[$];
  string      exp_t[$];

  logic        m_vld[16];
  logic [11:0] m_kp[16];
  logic [11:0] m_np[16];
  logic [15:0] m_kc[16];
  logic [15:0] m_nc[16];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_crc(input logic [31:0] w);
    logic [7:0] r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      if (r[7] ^ w[i]) r = {r[6:0], 1'b0} ^ 8'h07;
      else             r = {r[6:0], 1'b0};
    end
    return r ^ 8'h55;
  endfunction

  task automatic put_byte(input logic [7:0] b, input logic s);
    in_valid = 1'b1;
    in_data  = b;
    in_soc   = s;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_soc   = 1'b0;
  endtask

  task automatic tbl_write(input int idx, input logic v, input logic [11:0] kp,
                           input logic [15:0] kc, input logic [11:0] np,
                           input logic [15:0] nc);
    tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_vld = v;
    tbl_key_path = kp; tbl_key_circ = kc; tbl_new_path = np; tbl_new_circ = nc;
    m_vld[idx] = v; m_kp[idx] = kp; m_kc[idx] = kc; m_np[idx] = np; m_nc[idx] = nc;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // driver: computes the expected cell, pushes it, then feeds the bytes
  task automatic send_cell(input logic [31:0] w, input bit corrupt,
                           input string tag, input int seed);
    logic [7:0]  hec;
    logic [11:0] ip;
    logic [31:0] ew;
    int          sel;
    hec = tb_crc(w) ^ (corrupt ? 8'h01 : 8'h00);
    ip  = nni_mode ? w[31:20] : {4'h0, w[27:20]};
    sel = -1;
    for (int i = 15; i >= 0; i--)
      if (m_vld[i] && m_kp[i] == ip && (path_only || m_kc[i] == w[19:4])) sel = i;
    if (corrupt || sel < 0) begin
      exp_drops++;
    end else begin
      ew = w;
      ew[27:20] = m_np[sel][7:0];
      if (nni_mode)   ew[31:28] = m_np[sel][11:8];
      if (!path_only) ew[19:4]  = m_nc[sel];
      for (int k = 0; k < 4; k++) begin
        exp_d.push_back(ew[31-8*k -: 8]); exp_s.push_back(k == 0); exp_t.push_back(tag);
      end
      exp_d.push_back(tb_crc(ew)); exp_s.push_back(1'b0); exp_t.push_back("R7 check byte");
      for (int k = 0; k < 48; k++) begin
        exp_d.push_back(8'((seed * 7 + k * 13 + 1) & 255));
        exp_s.push_back(1'b0);
        exp_t.push_back("R8 payload");
      end
    end
    for (int k = 0; k < 4; k++) put_byte(w[31-8*k -: 8], k == 0);
    put_byte(hec, 1'b0);
    for (int k = 0; k < 48; k++) put_byte(8'((seed * 7 + k * 13 + 1) & 255), 1'b0);
  endtask

  task automatic settle();
    while (exp_d.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops and compares each accepted output byte
  initial begin
    logic [7:0] ed;
    logic       es;
    string      et;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R3 unexpected output byte", out_data, 0);
        end else begin
          ed = exp_d.pop_front(); es = exp_s.pop_front(); et = exp_t.pop_front();
          chk(out_data == ed, et, out_data, ed);
          chk(out_soc == es, "R1 start flag", out_soc, es);
        end
      end
    end
  end

  // downstream readiness, pseudo-random when stalling is enabled
  initial begin
    logic [7:0] lfsr = 8'hA5;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = stall_en ? lfsr[0] : 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 1'b0; m_kp[i] = '0; m_kc[i] = '0; m_np[i] = '0; m_nc[i] = '0;
    end
    rst_n = 1'b0; nni_mode = 1'b0; path_only = 1'b0;
    in_valid = 1'b0; in_soc = 1'b0; in_data = 8'h00;
    tbl_we = 1'b0; tbl_idx = '0; tbl_vld = 1'b0;
    tbl_key_path = '0; tbl_key_circ = '0; tbl_new_path = '0; tbl_new_circ = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);
    chk(drop_count == 16'd0, "R11 drop_count after reset", drop_count, 0);

    // R11: empty table drops everything
    send_cell({4'h3, 8'h12, 16'h0100, 4'h2}, 1'b0, "R11", 1);
    settle();
    chk(drop_count == 16'(exp_drops), "R11 empty table drop", drop_count, exp_drops);

    // R10: load the table
    tbl_write(0, 1'b1, 12'h012, 16'h0100, 12'h034, 16'h0200);
    tbl_write(1, 1'b1, 12'h012, 16'h0101, 12'h056, 16'h0300);
    tbl_write(2, 1'b1, 12'h0AB, 16'h0000, 12'h0CD, 16'h0000);
    tbl_write(3, 1'b1, 12'h012, 16'h0100, 12'h0EE, 16'h0EEE);
    tbl_write(5, 1'b1, 12'hABC, 16'h0005, 12'h123, 16'h0777);

    // R4 R6 R3: host layout, full match, entry 0 beats duplicate entry 3
    send_cell({4'hA, 8'h12, 16'h0100, 4'h5}, 1'b0, "R4 R6 R3 header", 2);
    send_cell({4'h6, 8'h12, 16'h0101, 4'hF}, 1'b0, "R4 header", 3);
    settle();

    // R5: path-only mode, circuit unchanged
    path_only = 1'b1;
    send_cell({4'h1, 8'hAB, 16'h1234, 4'h9}, 1'b0, "R5 header", 4);
    send_cell({4'h2, 8'h12, 16'hBEEF, 4'h0}, 1'b0, "R5 R3 header", 5);
    settle();
    path_only = 1'b0;

    // R6: switch layout, 12-bit path replaced
    nni_mode = 1'b1;
    send_cell({12'hABC, 16'h0005, 4'h3}, 1'b0, "R6 switch header", 6);
    settle();
    nni_mode = 1'b0;

    // R2: corrupted check byte on a known connection
    send_cell({4'hA, 8'h12, 16'h0100, 4'h5}, 1'b1, "R2", 7);
    settle();
    chk(drop_count == 16'(exp_drops), "R2 bad check byte drop", drop_count, exp_drops);

    // R3: miss, then bad check plus miss counted once
    send_cell({4'h0, 8'h77, 16'h0042, 4'h1}, 1'b0, "R3", 8);
    settle();
    chk(drop_count == 16'(exp_drops), "R3 miss drop", drop_count, exp_drops);
    send_cell({4'h0, 8'h78, 16'h0043, 4'h1}, 1'b1, "R3", 9);
    settle();
    chk(drop_count == 16'(exp_drops), "R3 double fault counted once", drop_count, exp_drops);

    // R1: stray bytes without start flag are skipped
    put_byte(8'hEE, 1'b0); put_byte(8'h12, 1'b0); put_byte(8'h01, 1'b0);
    send_cell({4'h4, 8'h12, 16'h0100, 4'h6}, 1'b0, "R1 header after stray bytes", 10);
    settle();

    // R9: downstream stalls
    stall_en = 1'b1;
    send_cell({4'h5, 8'h12, 16'h0101, 4'h7}, 1'b0, "R9 header", 11);
    send_cell({4'h7, 8'h12, 16'h0100, 4'h8}, 1'b0, "R9 header", 12);
    settle();
    stall_en = 1'b0;

    // R10: invalidate entry 0, duplicate entry 3 now serves the key
    tbl_write(0, 1'b0, 12'h012, 16'h0100, 12'h034, 16'h0200);
    send_cell({4'h9, 8'h12, 16'h0100, 4'hC}, 1'b0, "R10 header", 13);
    settle();
    chk(drop_count == 16'(exp_drops), "R10 final drop count", drop_count, exp_drops);
    chk(exp_d.size() == 0, "R8 all expected bytes seen", exp_d.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule